// File: doc/BRIEF.md
# Grouped-Priority Channel Arbiter

This block picks one winner per clock cycle from up to 32 DMA channel request lines. Each channel gets one of four priority levels from bits 3:2 of its index, so the lower sixteen channels and the upper sixteen share the same level pattern. Level 0 covers channels 0–3 and 16–19, level 1 covers 4–7 and 20–23, level 2 covers 8–11 and 24–27, and level 3 covers 12–15 and 28–31. The lowest non-empty level always wins. Inside that level the requester with the smallest index wins. Channel 16 therefore beats channel 4, and channel 3 beats channel 16.

The winner is held in registers and is presented in two forms: as a one-hot grant vector, and as an index with a valid flag. A small two-state machine tracks whether a grant is being held. `ARB_IDLE` means no grant is held. `ARB_GRANT` means a winner is being presented. In every cycle the machine takes the transition `to_grant` when any channel requests, and the transition `to_idle` when none does. This applies from either state.

Alongside the arbiter, a 32-bit status word collects each channel's pending-interrupt line into the bit with the same index. Software can scan this word from its lowest set bit upward. Bits above the configured channel count read as zero.

Top module: `grp_prio_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `grant` is all zeros, `grant_idx` is 0, `grant_vld` is 0 and `irq_status` is all zeros.
- R2: A channel's level is (index & 15) >> 2. A requester at a lower level is granted over every requester at a higher level, whatever their indices (for example, 16 beats 4 and 19 beats 12).
- R3: Among requesters at the same level, the one with the smallest index is granted (for example, 3 beats 16 and 16 beats 19).
- R4: The grant is registered. The outputs after a rising edge reflect the `req_in` value sampled at that edge. A change of `req_in` between edges leaves the outputs unchanged until the next edge.
- R5: When no channel requests at an edge, the outputs after that edge are `grant_vld` = 0, `grant` = 0 and `grant_idx` = 0 (state `ARB_IDLE`).
- R6: When `grant_vld` is 1, `grant` has exactly one bit set, at position `grant_idx`. When `grant_vld` is 0, `grant` is zero.
- R7: After each edge, bit n of `irq_status` equals `irq_src[n]` as sampled at that edge, for n < NUM_CH. Bits at or above NUM_CH are always 0.
- R8: A status bit stays set for as long as its source stays high, and it clears on the first edge at which its source is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | NUM_CH | Per-channel request lines |
| irq_src | input | NUM_CH | Per-channel pending-interrupt lines |
| grant | output | NUM_CH | Registered one-hot grant |
| grant_idx | output | 5 | Index of the granted channel |
| grant_vld | output | 1 | A grant is being presented |
| irq_status | output | 32 | Aggregate interrupt status, one bit per channel |

## Verification
The hardest case to reach is a competition across the two halves of the channel range. Here a higher index must beat a lower one because its level is lower, and a tie inside one level must still fall to the lower half. Random request words seldom isolate exactly that pair. The stimulus therefore sweeps every ordered pair of single requests on the 32-channel instance. It also drives all 64 request words on a second instance with six channels, where the level boundary falls inside the configuration. Pseudo-random dense words then cover many simultaneous requesters.

// File: rtl/gpa_pkg.sv
package gpa_pkg;
    localparam int MAX_CH  = 32;
    localparam int NUM_LVL = 4;
    localparam int IDX_W   = 5;
    localparam int STAT_W  = 32;

    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_GRANT = 1'b1
    } arb_state_e;

    // level of a channel: bits 3:2 of its index
    function automatic logic [1:0] ch_level(input int idx);
        return 2'((idx & 15) >> 2);
    endfunction
endpackage

// File: rtl/gpa_level_pick.sv
module gpa_level_pick
    import gpa_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int LVL    = 0
) (
    input  logic [NUM_CH-1:0] req,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    // scan from high to low so the lowest index in this level ends up held
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i] && (ch_level(i) == 2'(LVL))) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/gpa_irq_gather.sv
module gpa_irq_gather
    import gpa_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] irq_src,
    output logic [STAT_W-1:0] status
);
    logic [STAT_W-1:0] status_q;

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= STAT_W'(irq_src);
    end

    assign status = status_q;

    // R8
    quiet_src_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_src == '0) |=> (status == '0));
endmodule

// File: rtl/grp_prio_arbiter.sv
module grp_prio_arbiter
    import gpa_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_in,
    input  logic [NUM_CH-1:0] irq_src,
    output logic [NUM_CH-1:0] grant,
    output logic [IDX_W-1:0]  grant_idx,
    output logic              grant_vld,
    output logic [STAT_W-1:0] irq_status
);
    logic [NUM_LVL-1:0] lvl_hit;
    logic [IDX_W-1:0]   lvl_idx [NUM_LVL];

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        gpa_level_pick #(.NUM_CH(NUM_CH), .LVL(l)) u_pick (
            .req (req_in),
            .hit (lvl_hit[l]),
            .idx (lvl_idx[l])
        );
    end

    logic             win_hit;
    logic [IDX_W-1:0] win_idx;

    // the lowest level that has a hit wins
    always_comb begin
        win_hit = 1'b0;
        win_idx = '0;
        for (int l = NUM_LVL - 1; l >= 0; l--) begin
            if (lvl_hit[l]) begin
                win_hit = 1'b1;
                win_idx = lvl_idx[l];
            end
        end
    end

    arb_state_e state_q, state_d;

    always_comb begin
        state_d = win_hit ? ARB_GRANT : ARB_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    logic [NUM_CH-1:0] grant_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            idx_q   <= '0;
        end else begin
            unique case (state_d)
                ARB_IDLE: begin
                    grant_q <= '0;
                    idx_q   <= '0;
                end
                ARB_GRANT: begin
                    for (int i = 0; i < NUM_CH; i++)
                        grant_q[i] <= (win_idx == IDX_W'(i));
                    idx_q <= win_idx;
                end
                default: begin
                    grant_q <= '0;
                    idx_q   <= '0;
                end
            endcase
        end
    end

    assign grant     = grant_q;
    assign grant_idx = idx_q;
    assign grant_vld = (state_q == ARB_GRANT);

    gpa_irq_gather #(.NUM_CH(NUM_CH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_src (irq_src),
        .status  (irq_status)
    );

    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R6
    vld_matches_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld == (grant != '0));

    // R4
    req_gets_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_in != '0) |=> (grant_vld && grant[grant_idx]));

    // R5
    no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_in == '0) |=> (!grant_vld && grant_idx == '0));
endmodule

// File: tb/sim_grp_prio_arbiter.sv
module sim_grp_prio_arbiter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] req0 = '0, irq0 = '0;
    logic [5:0]  req1 = '0, irq1 = '0;
    logic [31:0] g0, st0, st1;
    logic [5:0]  g1;
    logic [4:0]  ix0, ix1;
    logic        v0, v1;

    int checks = 0;
    int errors = 0;

    grp_prio_arbiter #(.NUM_CH(32)) u0 (
        .clk(clk), .rst_n(rst_n), .req_in(req0), .irq_src(irq0),
        .grant(g0), .grant_idx(ix0), .grant_vld(v0), .irq_status(st0));

    grp_prio_arbiter #(.NUM_CH(6)) u1 (
        .clk(clk), .rst_n(rst_n), .req_in(req1), .irq_src(irq1),
        .grant(g1), .grant_idx(ix1), .grant_vld(v1), .irq_status(st1));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [31:0] r, input int n, output int idx, output bit v);
        v = 0; idx = 0;
        for (int l = 0; l < 4; l++)
            for (int i = 0; i < n; i++)
                if (!v && r[i] && (((i & 15) >> 2) == l)) begin
                    v = 1; idx = i;
                end
    endfunction

    task automatic run0(input logic [31:0] r, input string tag);
        int ei; bit ev; logic [31:0] eg;
        @(negedge clk); req0 = r;
        @(posedge clk); #1;
        model(r, 32, ei, ev);
        eg = ev ? (32'd1 << ei) : 32'd0;
        chk(v0 == ev && ix0 == 5'(ei) && g0 == eg, tag, {g0[30:0], v0}, {eg[30:0], ev});
        chk(ix0 == 5'(ei), tag, 32'(ix0), 32'(ei));
    endtask

    task automatic run1(input logic [5:0] r, input string tag);
        int ei; bit ev; logic [5:0] eg;
        @(negedge clk); req1 = r;
        @(posedge clk); #1;
        model(32'(r), 6, ei, ev);
        eg = ev ? 6'(6'd1 << ei) : 6'd0;
        chk(v1 == ev && ix1 == 5'(ei) && g1 == eg, tag, {20'd0, ix1, g1, v1}, {20'd0, 5'(ei), eg, ev});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        // R1 reset state, also with requests present
        req0 = 32'hFFFF_FFFF; irq0 = 32'hFFFF_FFFF; req1 = 6'h3F; irq1 = 6'h3F;
        repeat (3) @(posedge clk);
        #1;
        chk(!v0 && g0 == 0 && ix0 == 0 && st0 == 0, "R1 u0 reset", {g0[30:0], v0}, 0);
        chk(!v1 && g1 == 0 && st1 == 0, "R1 u1 reset", st1, 0);
        @(negedge clk); req0 = 0; irq0 = 0; req1 = 0; irq1 = 0; rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!v0 && g0 == 0 && st0 == 0, "R1 first cycle", {g0[30:0], v0}, 0);

        // R5 no request
        run0(32'd0, "R5 empty");
        run1(6'd0, "R5 empty u1");

        // R6 single requester on every channel
        for (int i = 0; i < 32; i++) run0(32'd1 << i, "R6 single");

        // R2 / R3 every ordered pair, including cross-half ties
        for (int i = 0; i < 32; i++)
            for (int j = 0; j < 32; j++)
                if (i != j)
                    run0((32'd1 << i) | (32'd1 << j),
                         (((i & 15) >> 2) != ((j & 15) >> 2)) ? "R2 pair" : "R3 pair");

        // named corner cases
        run0(32'h0001_0010, "R2 ch16 beats ch4");
        run0(32'h0008_1000, "R2 ch19 beats ch12");
        run0(32'h0001_0008, "R3 ch3 beats ch16");
        run0(32'h0009_0000, "R3 ch16 beats ch19");
        run0(32'hF000_F000, "R3 level3 only");

        // R2 dense pseudo-random words
        lf = 32'hACE1_2357;
        for (int k = 0; k < 1500; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            run0(lf & {lf[15:0], lf[31:16]}, "R2 random");
        end

        // R2 / R3 exhaustive on the 6-channel instance
        for (int r = 0; r < 64; r++) run1(6'(r), "R3 u1 sweep");

        // R4 change between edges is not visible until the next edge
        run0(32'h0000_0100, "R4 setup");
        @(negedge clk); req0 = 32'h0000_0002; #1;
        chk(v0 && ix0 == 5'd8, "R4 before edge", 32'(ix0), 32'd8);
        @(posedge clk); #1;
        chk(v0 && ix0 == 5'd1, "R4 after edge", 32'(ix0), 32'd1);
        @(negedge clk); req0 = 0; #1;
        chk(v0 && ix0 == 5'd1, "R4 hold", 32'(ix0), 32'd1);
        @(posedge clk); #1;
        chk(!v0 && g0 == 0 && ix0 == 0, "R5 drop", {g0[30:0], v0}, 0);

        // R7 status tracks sources, upper bits of small config are zero
        @(negedge clk); irq0 = 32'h8001_0420; irq1 = 6'h25;
        @(posedge clk); #1;
        chk(st0 == 32'h8001_0420, "R7 u0", st0, 32'h8001_0420);
        chk(st1 == 32'h0000_0025, "R7 u1 upper zero", st1, 32'h25);
        @(negedge clk); irq1 = 6'h3F;
        @(posedge clk); #1;
        chk(st1 == 32'h0000_003F, "R7 u1 all", st1, 32'h3F);

        // R8 hold while high, clear when source drops
        repeat (3) @(posedge clk);
        #1;
        chk(st0 == 32'h8001_0420, "R8 held", st0, 32'h8001_0420);
        @(negedge clk); irq0 = 32'h8000_0420; #1;
        chk(st0 == 32'h8001_0420, "R8 before edge", st0, 32'h8001_0420);
        @(posedge clk); #1;
        chk(st0 == 32'h8000_0420, "R8 cleared bit16", st0, 32'h8000_0420);
        @(negedge clk); irq0 = 0; irq1 = 0;
        @(posedge clk); #1;
        chk(st0 == 0 && st1 == 0, "R8 all clear", st0 | st1, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule